// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog

This peripheral guards a system against software that stops making progress. Once enabled, it counts oscillator cycles, which arrive as a tick qualifier on the register-bus clock. It compares the count against a window set by a 12-bit period field N. Each window is (N+1)·2^PRESCALE_LOG2 ticks long. With the default prescale exponent of 20, that is (N+1) mebi-ticks.

When the first window runs out, the block raises an interrupt and starts a second window. If the second window also runs out with no keep-alive write in between, the block asserts its reset output and holds it there.

Software keeps the system alive by writing a 1 to the kick register. The kick acts at once. It clears the count, the pending interrupt and the overflow stage. All other register writes pass through a fixed settling delay of SETTLE_CYC clock cycles, which stands in for the crossing into the oscillator domain.

A separate path lets software force a fault. It first clears a guard bit, then writes the fault-force register. The reset output then asserts without waiting for any window.

Top module: `wdt_dual_overflow`

## Requirements
- R1: After reset, `irq_o` and `wdt_rst_o` are 0, and reads of 0x00, 0x04 and 0x08 return 0. A read of 0x10 returns 1, because the guard bit powers up set. A read of 0x0C returns 0.
- R2: The period register at 0x04 holds only bits [31:20], as the 12-bit value N. Bits [19:0] are ignored on write and read back as 0.
- R3: A write to offset 0x00, 0x04, 0x08, 0x10 or 0x14 takes effect exactly SETTLE_CYC clock edges after the edge that samples it. A write to 0x0C takes effect on the sampling edge itself.
- R4: While the block is enabled, the count at 0x08 rises by one on each edge where `osc_tick` is 1. It holds when `osc_tick` is 0. A write to 0x08 loads the written value into the count.
- R5: After a kick, `irq_o` rises exactly (N+1)·2^PRESCALE_LOG2 ticks later. It is still 0 one tick before that. A read of 0x0C returns `irq_o` in bit 0.
- R6: If no kick arrives, `wdt_rst_o` rises exactly (N+1)·2^PRESCALE_LOG2 ticks after `irq_o` rose, and not one tick earlier.
- R7: Writing 1 to bit 0 of 0x0C clears the count, `irq_o` and the overflow stage. After a kick, a fresh first window follows. Writing 0 to bit 0 of 0x0C has no effect. A kick on the same edge as an overflow wins: `irq_o` stays 0 and the count restarts.
- R8: Writing 1 to bit 0 of 0x00 enables counting, and the enable is sticky until reset. A later write of 0 is ignored. A period write that settles while the block is enabled is ignored.
- R9: When bit 0 of 0x10 is 0, a write with bit 0 of 0x14 set asserts `wdt_rst_o`, on the edge given by R3. When bit 0 of 0x10 is 1, that write has no effect.
- R10: Once `wdt_rst_o` is 1, it stays 1 through kicks and any other writes until `rst_n` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| osc_tick | input | 1 | Qualifier marking one oscillator cycle per clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | First-overflow interrupt |
| wdt_rst_o | output | 1 | Sticky reset request |

## Verification
A keep-alive write and the end of a window can land on the same clock edge. The kick bypasses the settling delay, while the overflow is decided from the registered count, so the two really can meet. The bench provokes this by issuing a kick, counting exactly one window of edges, and landing a second kick on the overflow edge. It then judges that `irq_o` stays low, that the count reads zero, and that the next interrupt arrives one full window later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Byte offsets decoded by software; the order is part of the register contract
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_PERIOD = 'h04;
  localparam int OFS_ELAPSE = 'h08;
  localparam int OFS_KICK   = 'h0C;
  localparam int OFS_GUARD  = 'h10;
  localparam int OFS_FAULT  = 'h14;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdt_settle.sv
module wdt_settle #(
  parameter int DEPTH = 15,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [AW-1:0]    adr_q [DEPTH];
  logic [AW-1:0]    adr_d [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DW-1:0]    dat_d [DEPTH];

  always_comb begin
    vld_d[0] = in_vld;
    adr_d[0] = in_addr;
    dat_d[0] = in_data;
    for (int i = 1; i < DEPTH; i++) begin
      vld_d[i] = vld_q[i-1];
      adr_d[i] = adr_q[i-1];
      dat_d[i] = dat_q[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        adr_q[g] <= '0;
        dat_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_d[g];
        if (vld_d[g]) begin
          adr_q[g] <= adr_d[g];
          dat_q[g] <= dat_d[g];
        end
      end
    end
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_addr = adr_q[DEPTH-1];
  assign out_data = dat_q[DEPTH-1];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int PRESCALE_LOG2 = 20,
  parameter int PERIOD_W      = 12,
  localparam int CNT_W        = PRESCALE_LOG2 + PERIOD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                kick_i,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    load_val_i,
  input  logic                force_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                irq_o,
  output logic                rst_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stage_q, stage_d;
  logic             irq_q, irq_d;
  logic             rst_q, rst_d;
  logic [CNT_W-1:0] limit;
  logic             step;
  logic             wrap;

  // Last count of a window: (N+1)*2^P - 1
  assign limit = {period_i, {PRESCALE_LOG2{1'b1}}};
  assign step  = run_i & tick_i;
  assign wrap  = step & (cnt_q >= limit);

  always_comb begin
    cnt_d   = cnt_q;
    stage_d = stage_q;
    irq_d   = irq_q;
    rst_d   = rst_q | force_i;
    if (kick_i) begin
      cnt_d   = '0;
      stage_d = 1'b0;
      irq_d   = 1'b0;
    end else if (load_i) begin
      cnt_d = load_val_i;
    end else if (wrap) begin
      cnt_d = '0;
      if (stage_q) begin
        rst_d = 1'b1;
      end else begin
        stage_d = 1'b1;
        irq_d   = 1'b1;
      end
    end else if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      irq_q   <= irq_d;
      rst_q   <= rst_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
  assign rst_o = rst_q;

  // R10
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);

  // R7
  kick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (!irq_q && cnt_q == '0));

  // R6
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(stage_q && wrap && !kick_i && !load_i) || $past(force_i)));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(run_i && tick_i && !stage_q));
endmodule

// File: rtl/wdt_dual_overflow.sv
module wdt_dual_overflow #(
  parameter int PRESCALE_LOG2 = 20,
  parameter int PERIOD_W      = 12,
  parameter int SETTLE_CYC    = 15,
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  import wdt_pkg::*;

  localparam int CNT_W   = PRESCALE_LOG2 + PERIOD_W;
  localparam int PER_LSB = DATA_W - PERIOD_W;

  logic                srst_n;
  logic                s_vld;
  logic [ADDR_W-1:0]   s_addr;
  logic [DATA_W-1:0]   s_data;
  logic                run_q, run_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic                guard_q, guard_d;
  logic                hit_ctrl, hit_per, hit_elp, hit_grd, hit_flt;
  logic                kick, fault;
  logic                is_kick_addr;
  logic [CNT_W-1:0]    cnt;

  wdt_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign is_kick_addr = (bus_addr == ADDR_W'(OFS_KICK));
  assign kick         = bus_wr & is_kick_addr & bus_wdata[0];

  wdt_settle #(
    .DEPTH (SETTLE_CYC),
    .AW    (ADDR_W),
    .DW    (DATA_W)
  ) u_settle (
    .clk      (clk),
    .rst_n    (srst_n),
    .in_vld   (bus_wr & ~is_kick_addr),
    .in_addr  (bus_addr),
    .in_data  (bus_wdata),
    .out_vld  (s_vld),
    .out_addr (s_addr),
    .out_data (s_data)
  );

  assign hit_ctrl = s_vld & (s_addr == ADDR_W'(OFS_CTRL));
  assign hit_per  = s_vld & (s_addr == ADDR_W'(OFS_PERIOD));
  assign hit_elp  = s_vld & (s_addr == ADDR_W'(OFS_ELAPSE));
  assign hit_grd  = s_vld & (s_addr == ADDR_W'(OFS_GUARD));
  assign hit_flt  = s_vld & (s_addr == ADDR_W'(OFS_FAULT));
  assign fault    = hit_flt & s_data[0] & ~guard_q;

  always_comb begin
    run_d    = run_q | (hit_ctrl & s_data[0]);
    period_d = period_q;
    guard_d  = guard_q;
    if (hit_per && !run_q) period_d = s_data[DATA_W-1 -: PERIOD_W];
    if (hit_grd)           guard_d  = s_data[0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q    <= 1'b0;
      period_q <= '0;
      guard_q  <= 1'b1;
    end else begin
      run_q    <= run_d;
      period_q <= period_d;
      guard_q  <= guard_d;
    end
  end

  wdt_counter #(
    .PRESCALE_LOG2 (PRESCALE_LOG2),
    .PERIOD_W      (PERIOD_W)
  ) u_counter (
    .clk        (clk),
    .rst_n      (srst_n),
    .run_i      (run_q),
    .tick_i     (osc_tick),
    .period_i   (period_q),
    .kick_i     (kick),
    .load_i     (hit_elp),
    .load_val_i (CNT_W'(s_data)),
    .force_i    (fault),
    .cnt_o      (cnt),
    .irq_o      (irq_o),
    .rst_o      (wdt_rst_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):   bus_rdata[0] = run_q;
      ADDR_W'(OFS_PERIOD): bus_rdata    = {period_q, {PER_LSB{1'b0}}};
      ADDR_W'(OFS_ELAPSE): bus_rdata    = DATA_W'(cnt);
      ADDR_W'(OFS_KICK):   bus_rdata[0] = irq_o;
      ADDR_W'(OFS_GUARD):  bus_rdata[0] = guard_q;
      default:             bus_rdata    = '0;
    endcase
  end

  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    run_q |=> run_q);

  // R8
  period_lock_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(run_q) |-> $stable(period_q));
endmodule

// File: tb/wdt_dual_overflow_tb.sv
module wdt_dual_overflow_tb;
  localparam int P   = 4;
  localparam int S   = 4;
  localparam int AW  = 5;
  localparam int DW  = 32;
  localparam int WIN = 1 << P;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          osc_tick;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;
  logic          wdt_rst_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdt_dual_overflow #(
    .PRESCALE_LOG2 (P),
    .PERIOD_W      (12),
    .SETTLE_CYC    (S),
    .ADDR_W        (AW),
    .DATA_W        (DW)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .wdt_rst_o (wdt_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    osc_tick = 1'b1;
    bus_wr   = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic start(input int n);
    do_reset();
    wr(5'h04, 32'(n) << 20);
    step(S);
    wr(5'h08, 32'h0);
    step(S);
    wr(5'h00, 32'h1);
    step(S);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;

    // R1 reset state
    do_reset();
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rst", 32'(wdt_rst_o), 0);
    rd(5'h00, d); chk("R1 ctrl", d, 0);
    rd(5'h04, d); chk("R1 period", d, 0);
    rd(5'h08, d); chk("R1 count", d, 0);
    rd(5'h0C, d); chk("R1 irq reg", d, 0);
    rd(5'h10, d); chk("R1 guard", d, 1);

    // R2 low bits ignored, R3 settling edge
    wr(5'h04, 32'hFFFF_FFFF);
    step(S - 1);
    rd(5'h04, d); chk("R3 before settle", d, 0);
    step(1);
    rd(5'h04, d); chk("R2 R3 period mask", d, 32'hFFF0_0000);

    // R5 R6 R10 sweep over N
    for (int n = 0; n < 4; n++) begin
      int len;
      len = WIN * (n + 1);
      start(n);
      rd(5'h04, d); chk("R2 period readback", d, 32'(n) << 20);
      wr(5'h0C, 32'h1);
      step(len - 1);
      chk("R5 irq one tick early", 32'(irq_o), 0);
      rd(5'h08, d); chk("R4 count", d, 32'(len - 1));
      step(1);
      chk("R5 irq at window end", 32'(irq_o), 1);
      rd(5'h0C, d); chk("R5 irq reg", d, 1);
      step(len - 1);
      chk("R6 rst one tick early", 32'(wdt_rst_o), 0);
      step(1);
      chk("R6 rst after second window", 32'(wdt_rst_o), 1);
      wr(5'h0C, 32'h1);
      step(3);
      chk("R10 rst sticky", 32'(wdt_rst_o), 1);
    end

    // R7 kick behaviour, N=0
    start(0);
    wr(5'h0C, 32'h1);
    step(WIN);
    chk("R7 irq up", 32'(irq_o), 1);
    wr(5'h0C, 32'h0);
    chk("R7 zero write ignored", 32'(irq_o), 1);
    wr(5'h0C, 32'h1);
    chk("R7 kick clears irq", 32'(irq_o), 0);
    rd(5'h08, d); chk("R7 kick clears count", d, 0);
    step(WIN);
    chk("R7 fresh first window irq", 32'(irq_o), 1);
    chk("R7 fresh first window no rst", 32'(wdt_rst_o), 0);

    // R7 kick lands on overflow edge
    wr(5'h0C, 32'h1);
    step(WIN - 1);
    wr(5'h0C, 32'h1);
    chk("R7 collision irq low", 32'(irq_o), 0);
    rd(5'h08, d); chk("R7 collision count", d, 0);
    step(WIN - 1);
    chk("R7 collision next window early", 32'(irq_o), 0);
    step(1);
    chk("R7 collision next window irq", 32'(irq_o), 1);

    // R8 sticky enable and locked period
    wr(5'h00, 32'h0);
    step(S);
    rd(5'h00, d); chk("R8 enable sticky", d, 1);
    wr(5'h04, 32'h0050_0000);
    step(S);
    rd(5'h04, d); chk("R8 period locked", d, 0);

    // R4 load and tick gating
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h5);
    step(S);
    rd(5'h08, d); chk("R4 load", d, 5);
    step(2);
    rd(5'h08, d); chk("R4 increment", d, 7);
    osc_tick = 1'b0;
    step(3);
    rd(5'h08, d); chk("R4 hold without tick", d, 7);
    osc_tick = 1'b1;

    // R9 forced fault
    do_reset();
    wr(5'h14, 32'h1);
    step(S + 2);
    chk("R9 guarded force ignored", 32'(wdt_rst_o), 0);
    wr(5'h10, 32'h0);
    step(S);
    rd(5'h10, d); chk("R9 guard cleared", d, 0);
    wr(5'h14, 32'h1);
    step(S - 1);
    chk("R9 force before settle", 32'(wdt_rst_o), 0);
    step(1);
    chk("R9 force asserts rst", 32'(wdt_rst_o), 1);
    do_reset();
    chk("R10 cleared by rst_n", 32'(wdt_rst_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule